// File: doc/BRIEF.md
# Set-Associative Cache Tag Store

This block holds the tag side of a set-associative cache. A lookup takes an address and a secure-space flag. One cycle later it reports hit or miss, the way that matched, the access latency in cycles and the entry's updated reference count. A fill takes an address, a requester ID and the cycle at which the line's data will arrive. The block picks a victim way in the addressed set and installs the new tag. When the victim held a valid line, it reports the rebuilt address of the evicted line. An invalidate clears a single entry selected by set and way.

A runtime limit on the number of usable ways applies to both lookup and victim search. Writes that fall outside the range 1 to WAYS are refused. The block keeps statistics:

- per-requester occupancy,
- the number of valid entries,
- tag-array and data-array access counts,
- the number of replacements,
- a running sum of the reference counts of evicted lines.

A free-running cycle counter serves as the time base for pending fills.

Top module: `cache_tag_store`

## Requirements
- R1: After reset no entry is valid. All statistics and `cycle_now` read zero, `alloc_ways` equals WAYS, and `lkp_done`, `fill_done` and `cfg_err` are low.
- R2: At most one of `cfg_we`, `lkp_req`, `fill_req`, `inv_req` is high in a cycle. The tag is `addr >> TAG_SHIFT` and the set is `(addr >> SET_SHIFT)` masked to SET_BITS. `lkp_done` pulses one cycle after `lkp_req`. A hit needs a valid entry in a way below the limit whose tag and secure bit both equal the request. `lkp_way` gives the lowest such way.
- R3: A miss reports `lkp_lat` = LOOKUP_LAT and `lkp_refs` = 0.
- R4: A hit reports `lkp_lat` = ACCESS_LAT, except in one case. When the entry's ready cycle is later than the cycle of the request and the remaining cycles exceed ACCESS_LAT, it reports remaining + ACCESS_LAT.
- R5: A hit increments the entry's reference count, and `lkp_refs` shows the new value. A fill starts the count at zero.
- R6: The fill victim is the lowest-numbered invalid way below the limit N. If all those ways are valid, the victim is way N-1. `fill_done` and `fill_way` appear one cycle after `fill_req`.
- R7: A fill that replaces a valid entry raises `evict_valid`. `evict_addr` equals `(old_tag << TAG_SHIFT) | (set << SET_SHIFT)`. The fill also adds 1 to `replacements`, adds the old reference count to `ref_total`, and subtracts 1 from the old owner's occupancy.
- R8: A fill into an invalid way adds 1 to `in_use`. Every fill adds 1 to the new owner's occupancy, whose counter sits at bits `owner*CNT_W` of `occupancy`.
- R9: A `cfg_we` write with a value from 1 to WAYS sets the limit. A value of 0 or above WAYS leaves the limit unchanged and pulses `cfg_err` for one cycle. A valid entry in a way at or above the limit does not hit.
- R10: Invalidating a valid entry clears it, subtracts 1 from `in_use` and subtracts 1 from its owner's occupancy. Invalidating an invalid entry changes nothing.
- R11: Each lookup adds N to `tag_accesses`. With SEQ_DATA=1 a lookup adds 1 to `data_accesses` only on a hit; with SEQ_DATA=0 it adds N on every lookup. A fill adds exactly 1 to each count.
- R12: `cycle_now` increases by one every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the allocatable way limit |
| cfg_ways | input | LIM_W | New way limit |
| alloc_ways | output | LIM_W | Current way limit |
| cfg_err | output | 1 | Rejected limit write (one-cycle pulse) |
| lkp_req | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_secure | input | 1 | Lookup secure-space flag |
| lkp_done | output | 1 | Lookup result valid |
| lkp_hit | output | 1 | Lookup hit |
| lkp_way | output | WAY_W | Way that hit |
| lkp_lat | output | TIME_W | Reported latency in cycles |
| lkp_refs | output | CNT_W | Entry reference count after the hit |
| fill_req | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Fill address |
| fill_secure | input | 1 | Fill secure-space flag |
| fill_owner | input | REQ_W | Requester ID of the new line |
| fill_ready | input | TIME_W | Cycle at which the line's data arrives |
| fill_done | output | 1 | Fill completed |
| fill_way | output | WAY_W | Way written by the fill |
| evict_valid | output | 1 | The fill replaced a valid line |
| evict_addr | output | ADDR_W | Rebuilt block address of the replaced line |
| inv_req | input | 1 | Invalidate request |
| inv_set | input | SET_BITS | Set to invalidate |
| inv_way | input | WAY_W | Way to invalidate |
| cycle_now | output | TIME_W | Free-running cycle counter |
| in_use | output | CNT_W | Number of valid entries |
| occupancy | output | REQS*CNT_W | Per-requester valid-entry counts |
| tag_accesses | output | CNT_W | Tag-array access count |
| data_accesses | output | CNT_W | Data-array access count |
| replacements | output | CNT_W | Replacements of valid lines |
| ref_total | output | CNT_W | Sum of reference counts of evicted lines |

## Verification
The assertions assume that the four request strobes are mutually exclusive, so that no lookup, fill, invalidate and limit write ever compete for the arrays in the same cycle. They also assume `fill_ready` is within half the counter range of `cycle_now`, so the unsigned ready comparison stays meaningful. The bench drives one operation at a time from tasks, leaves an idle cycle between operations, and sets ready cycles only a few tens of cycles ahead of the current count.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_CFG,
      OP_LOOKUP,
      OP_FILL,
      OP_INV
   } ctag_op_e;
endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   localparam int WAY_W = $clog2(WAYS),
   localparam int LIM_W = $clog2(WAYS + 1)
) (
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS-1:0]       secure,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [LIM_W-1:0]      limit,
   input  logic [TAG_W-1:0]      tag,
   input  logic                  sec,
   output logic                  hit,
   output logic [WAY_W-1:0]      way
);
   logic [WAYS-1:0] match;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (secure[g] == sec) &&
                        (tags[g*TAG_W +: TAG_W] == tag) &&
                        (LIM_W'(g) < limit);
   end

   always_comb begin
      hit = |match;
      way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (match[i]) way = WAY_W'(i);
   end
endmodule

// File: rtl/ctag_victim.sv
module ctag_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int LIM_W = $clog2(WAYS + 1)
) (
   input  logic [WAYS-1:0]  valid,
   input  logic [LIM_W-1:0] limit,
   output logic [WAY_W-1:0] way
);
   logic found;

   always_comb begin
      way   = WAY_W'(limit - LIM_W'(1));
      found = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && (LIM_W'(i) < limit) && !valid[i]) begin
            way   = WAY_W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ctag_latency.sv
module ctag_latency #(
   parameter int TIME_W     = 16,
   parameter int ACCESS_LAT = 3
) (
   input  logic [TIME_W-1:0] ready,
   input  logic [TIME_W-1:0] now,
   output logic [TIME_W-1:0] lat
);
   logic [TIME_W-1:0] remain;

   always_comb begin
      remain = ready - now;
      if ((ready > now) && (remain > TIME_W'(ACCESS_LAT)))
         lat = remain + TIME_W'(ACCESS_LAT);
      else
         lat = TIME_W'(ACCESS_LAT);
   end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
   import ctag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SET_SHIFT  = 6,
   parameter int SET_BITS   = 2,
   parameter int TAG_SHIFT  = 8,
   parameter int WAYS       = 4,
   parameter int REQS       = 4,
   parameter int CNT_W      = 16,
   parameter int TIME_W     = 16,
   parameter int LOOKUP_LAT = 2,
   parameter int ACCESS_LAT = 3,
   parameter bit SEQ_DATA   = 1'b1,
   localparam int SETS  = 1 << SET_BITS,
   localparam int TAG_W = ADDR_W - TAG_SHIFT,
   localparam int WAY_W = $clog2(WAYS),
   localparam int LIM_W = $clog2(WAYS + 1),
   localparam int REQ_W = $clog2(REQS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [LIM_W-1:0]      cfg_ways,
   output logic [LIM_W-1:0]      alloc_ways,
   output logic                  cfg_err,
   input  logic                  lkp_req,
   input  logic [ADDR_W-1:0]     lkp_addr,
   input  logic                  lkp_secure,
   output logic                  lkp_done,
   output logic                  lkp_hit,
   output logic [WAY_W-1:0]      lkp_way,
   output logic [TIME_W-1:0]     lkp_lat,
   output logic [CNT_W-1:0]      lkp_refs,
   input  logic                  fill_req,
   input  logic [ADDR_W-1:0]     fill_addr,
   input  logic                  fill_secure,
   input  logic [REQ_W-1:0]      fill_owner,
   input  logic [TIME_W-1:0]     fill_ready,
   output logic                  fill_done,
   output logic [WAY_W-1:0]      fill_way,
   output logic                  evict_valid,
   output logic [ADDR_W-1:0]     evict_addr,
   input  logic                  inv_req,
   input  logic [SET_BITS-1:0]   inv_set,
   input  logic [WAY_W-1:0]      inv_way,
   output logic [TIME_W-1:0]     cycle_now,
   output logic [CNT_W-1:0]      in_use,
   output logic [REQS*CNT_W-1:0] occupancy,
   output logic [CNT_W-1:0]      tag_accesses,
   output logic [CNT_W-1:0]      data_accesses,
   output logic [CNT_W-1:0]      replacements,
   output logic [CNT_W-1:0]      ref_total
);
   localparam int OWN_W = REQ_W + 1;
   localparam logic [OWN_W-1:0] NO_OWNER = {1'b1, {REQ_W{1'b0}}};

   // elaboration-time parameter checks
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end
   if (REQS < 2) begin : g_bad_reqs
      $error("REQS must be at least 2");
   end
   if (TAG_SHIFT < SET_SHIFT + SET_BITS) begin : g_bad_shift
      $error("tag field overlaps set index");
   end
   if (TAG_SHIFT >= ADDR_W) begin : g_bad_tag
      $error("TAG_SHIFT leaves no tag bits");
   end

   // storage
   logic [WAYS-1:0]   valid_q [SETS];
   logic [WAYS-1:0]   sec_q   [SETS];
   logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
   logic [OWN_W-1:0]  own_q   [SETS][WAYS];
   logic [CNT_W-1:0]  ref_q   [SETS][WAYS];
   logic [TIME_W-1:0] rdy_q   [SETS][WAYS];
   logic [CNT_W-1:0]  occ_q   [REQS];
   logic [CNT_W-1:0]  occ_n   [REQS];
   logic [LIM_W-1:0]  alloc_q;
   logic [TIME_W-1:0] now_q;

   ctag_op_e op;
   always_comb begin
      op = OP_NONE;
      if (cfg_we)        op = OP_CFG;
      else if (lkp_req)  op = OP_LOOKUP;
      else if (fill_req) op = OP_FILL;
      else if (inv_req)  op = OP_INV;
   end

   // address split
   logic [SET_BITS-1:0] l_set, f_set;
   logic [TAG_W-1:0]    l_tag, f_tag;
   assign l_set = lkp_addr[SET_SHIFT +: SET_BITS];
   assign l_tag = lkp_addr[ADDR_W-1:TAG_SHIFT];
   assign f_set = fill_addr[SET_SHIFT +: SET_BITS];
   assign f_tag = fill_addr[ADDR_W-1:TAG_SHIFT];

   logic [WAYS*TAG_W-1:0] l_tags;
   always_comb
      for (int w = 0; w < WAYS; w++) l_tags[w*TAG_W +: TAG_W] = tag_q[l_set][w];

   logic             m_hit;
   logic [WAY_W-1:0] m_way, v_way;
   logic [TIME_W-1:0] hit_lat;

   ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .valid(valid_q[l_set]), .secure(sec_q[l_set]), .tags(l_tags),
      .limit(alloc_q), .tag(l_tag), .sec(lkp_secure),
      .hit(m_hit), .way(m_way));

   ctag_victim #(.WAYS(WAYS)) u_victim (
      .valid(valid_q[f_set]), .limit(alloc_q), .way(v_way));

   ctag_latency #(.TIME_W(TIME_W), .ACCESS_LAT(ACCESS_LAT)) u_lat (
      .ready(rdy_q[l_set][m_way]), .now(now_q), .lat(hit_lat));

   // data-array access accounting variant
   logic [CNT_W-1:0] data_inc;
   if (SEQ_DATA) begin : g_seq
      assign data_inc = CNT_W'(m_hit);
   end else begin : g_par
      assign data_inc = CNT_W'(alloc_q);
   end

   // victim and invalidate targets
   logic             vic_valid, inv_hit;
   logic [CNT_W-1:0] vic_ref;
   assign vic_valid = valid_q[f_set][v_way];
   assign vic_ref   = ref_q[f_set][v_way];
   assign inv_hit   = valid_q[inv_set][inv_way];

   // occupancy next-state
   logic             dec_en, inc_en;
   logic [REQ_W-1:0] dec_id;
   assign dec_en = ((op == OP_FILL) && vic_valid) || ((op == OP_INV) && inv_hit);
   assign dec_id = (op == OP_FILL) ? own_q[f_set][v_way][REQ_W-1:0]
                                   : own_q[inv_set][inv_way][REQ_W-1:0];
   assign inc_en = (op == OP_FILL);

   always_comb begin
      for (int r = 0; r < REQS; r++) begin
         occ_n[r] = occ_q[r];
         if (dec_en && (dec_id == REQ_W'(r))) occ_n[r] = occ_n[r] - CNT_W'(1);
         if (inc_en && (fill_owner == REQ_W'(r))) occ_n[r] = occ_n[r] + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            sec_q[s]   <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w] <= '0;
               own_q[s][w] <= NO_OWNER;
               ref_q[s][w] <= '0;
               rdy_q[s][w] <= '0;
            end
         end
         for (int r = 0; r < REQS; r++) occ_q[r] <= '0;
         alloc_q       <= LIM_W'(WAYS);
         now_q         <= '0;
         cfg_err       <= 1'b0;
         lkp_done      <= 1'b0;
         lkp_hit       <= 1'b0;
         lkp_way       <= '0;
         lkp_lat       <= '0;
         lkp_refs      <= '0;
         fill_done     <= 1'b0;
         fill_way      <= '0;
         evict_valid   <= 1'b0;
         evict_addr    <= '0;
         in_use        <= '0;
         tag_accesses  <= '0;
         data_accesses <= '0;
         replacements  <= '0;
         ref_total     <= '0;
      end else begin
         now_q     <= now_q + TIME_W'(1);
         cfg_err   <= 1'b0;
         lkp_done  <= 1'b0;
         fill_done <= 1'b0;
         for (int r = 0; r < REQS; r++) occ_q[r] <= occ_n[r];
         case (op)
            OP_CFG: begin
               if ((cfg_ways == '0) || (cfg_ways > LIM_W'(WAYS))) cfg_err <= 1'b1;
               else alloc_q <= cfg_ways;
            end
            OP_LOOKUP: begin
               lkp_done      <= 1'b1;
               lkp_hit       <= m_hit;
               lkp_way       <= m_way;
               tag_accesses  <= tag_accesses + CNT_W'(alloc_q);
               data_accesses <= data_accesses + data_inc;
               if (m_hit) begin
                  ref_q[l_set][m_way] <= ref_q[l_set][m_way] + CNT_W'(1);
                  lkp_refs            <= ref_q[l_set][m_way] + CNT_W'(1);
                  lkp_lat             <= hit_lat;
               end else begin
                  lkp_refs <= '0;
                  lkp_lat  <= TIME_W'(LOOKUP_LAT);
               end
            end
            OP_FILL: begin
               fill_done   <= 1'b1;
               fill_way    <= v_way;
               evict_valid <= vic_valid;
               evict_addr  <= (ADDR_W'(tag_q[f_set][v_way]) << TAG_SHIFT) |
                              (ADDR_W'(f_set) << SET_SHIFT);
               if (vic_valid) begin
                  replacements <= replacements + CNT_W'(1);
                  ref_total    <= ref_total + vic_ref;
               end else begin
                  in_use <= in_use + CNT_W'(1);
               end
               valid_q[f_set][v_way] <= 1'b1;
               sec_q[f_set][v_way]   <= fill_secure;
               tag_q[f_set][v_way]   <= f_tag;
               own_q[f_set][v_way]   <= {1'b0, fill_owner};
               ref_q[f_set][v_way]   <= '0;
               rdy_q[f_set][v_way]   <= fill_ready;
               tag_accesses          <= tag_accesses + CNT_W'(1);
               data_accesses         <= data_accesses + CNT_W'(1);
            end
            OP_INV: begin
               if (inv_hit) begin
                  valid_q[inv_set][inv_way] <= 1'b0;
                  own_q[inv_set][inv_way]   <= NO_OWNER;
                  in_use                    <= in_use - CNT_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign alloc_ways = alloc_q;
   assign cycle_now  = now_q;
   for (genvar r = 0; r < REQS; r++) begin : g_occ
      assign occupancy[r*CNT_W +: CNT_W] = occ_q[r];
   end

   // assertions
   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_we, lkp_req, fill_req, inv_req})); // R2
   AST_LKP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_req |=> lkp_done); // R2
   AST_MISS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_done && !lkp_hit) |-> (lkp_lat == TIME_W'(LOOKUP_LAT))); // R3
   AST_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_done && lkp_hit) |-> (lkp_lat >= TIME_W'(ACCESS_LAT))); // R4
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (LIM_W'(fill_way) < alloc_q)); // R6
   AST_INUSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      in_use <= CNT_W'(SETS * WAYS)); // R8
   AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_q != '0) && (alloc_q <= LIM_W'(WAYS))); // R9
   AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $stable(alloc_q)); // R9
   AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_done && lkp_hit) |-> (LIM_W'(lkp_way) < alloc_q)); // R9
   AST_IDLE_STATS: assert property (@(posedge clk) disable iff (!rst_n)
      (!lkp_req && !fill_req) |=> $stable(tag_accesses)); // R11
endmodule

// File: tb/cache_tag_store_bench.sv
module cache_tag_store_bench;
   localparam int ADDR_W = 32, WAYS = 4, REQS = 4, CNT_W = 16, TIME_W = 16;
   localparam int LIM_W = 3, WAY_W = 2, REQ_W = 2, SET_BITS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic cfg_we = 0; logic [LIM_W-1:0] cfg_ways = '0;
   logic [LIM_W-1:0] alloc_ways; logic cfg_err;
   logic lkp_req = 0, lkp_secure = 0; logic [ADDR_W-1:0] lkp_addr = '0;
   logic lkp_done, lkp_hit; logic [WAY_W-1:0] lkp_way;
   logic [TIME_W-1:0] lkp_lat; logic [CNT_W-1:0] lkp_refs;
   logic fill_req = 0, fill_secure = 0; logic [ADDR_W-1:0] fill_addr = '0;
   logic [REQ_W-1:0] fill_owner = '0; logic [TIME_W-1:0] fill_ready = '0;
   logic fill_done, evict_valid; logic [WAY_W-1:0] fill_way; logic [ADDR_W-1:0] evict_addr;
   logic inv_req = 0; logic [SET_BITS-1:0] inv_set = '0; logic [WAY_W-1:0] inv_way = '0;
   logic [TIME_W-1:0] cycle_now; logic [CNT_W-1:0] in_use, tag_accesses, data_accesses;
   logic [CNT_W-1:0] replacements, ref_total; logic [REQS*CNT_W-1:0] occupancy;

   cache_tag_store u_cache_tag_store (
      .clk, .rst_n, .cfg_we, .cfg_ways, .alloc_ways, .cfg_err,
      .lkp_req, .lkp_addr, .lkp_secure, .lkp_done, .lkp_hit, .lkp_way, .lkp_lat, .lkp_refs,
      .fill_req, .fill_addr, .fill_secure, .fill_owner, .fill_ready,
      .fill_done, .fill_way, .evict_valid, .evict_addr,
      .inv_req, .inv_set, .inv_way, .cycle_now, .in_use, .occupancy,
      .tag_accesses, .data_accesses, .replacements, .ref_total);

   int total = 0, fails = 0;
   int exp_tag = 0, exp_data = 0, lim = WAYS;

   typedef struct packed {
      logic hit; logic [WAY_W-1:0] way; logic [TIME_W-1:0] lat; logic [CNT_W-1:0] refs;
   } exp_t;
   exp_t sb_q [$];

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: compare lookup results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && lkp_done) begin
         if (sb_q.size() == 0) chk("R2", "unexpected lkp_done", 1, 0);
         else begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R2", "lkp_hit", lkp_hit, e.hit);
            if (e.hit) chk("R2", "lkp_way", lkp_way, e.way);
            chk(e.hit ? "R4" : "R3", "lkp_lat", lkp_lat, e.lat);
            chk("R5", "lkp_refs", lkp_refs, e.refs);
         end
      end
   end

   function automatic int occ(input int r);
      return int'(occupancy[r*CNT_W +: CNT_W]);
   endfunction

   // exp_ready is the entry's ready cycle; latency follows R4
   task automatic lookup(input logic [ADDR_W-1:0] a, input logic s, input logic hit,
                         input int way, input int ready, input int refs);
      exp_t e;
      int now, lat;
      @(negedge clk);
      now = int'(cycle_now);
      lat = 3;
      if (hit && ready > now && ready - now > 3) lat = ready - now + 3;
      e.hit = hit; e.way = WAY_W'(way); e.lat = hit ? TIME_W'(lat) : TIME_W'(2);
      e.refs = hit ? CNT_W'(refs) : '0;
      sb_q.push_back(e);
      lkp_req = 1; lkp_addr = a; lkp_secure = s;
      exp_tag += lim; if (hit) exp_data += 1;   // R11 sequential mode
      @(negedge clk);
      lkp_req = 0;
   endtask

   task automatic fill(input logic [ADDR_W-1:0] a, input int owner, input int offs,
                       input int way, input logic ev, input logic [ADDR_W-1:0] ev_addr,
                       output int ready);
      @(negedge clk);
      ready = int'(cycle_now) + offs;
      fill_req = 1; fill_addr = a; fill_secure = 0; fill_owner = REQ_W'(owner);
      fill_ready = TIME_W'(ready);
      exp_tag += 1; exp_data += 1;
      @(negedge clk);
      fill_req = 0;
      chk("R6", "fill_done", fill_done, 1);
      chk("R6", "fill_way", fill_way, way);
      chk("R7", "evict_valid", evict_valid, ev);
      if (ev) chk("R7", "evict_addr", evict_addr, ev_addr);
   endtask

   task automatic cfg(input int v);
      @(negedge clk);
      cfg_we = 1; cfg_ways = LIM_W'(v);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic inval(input int s, input int w);
      @(negedge clk);
      inv_req = 1; inv_set = SET_BITS'(s); inv_way = WAY_W'(w);
      @(negedge clk);
      inv_req = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   localparam logic [ADDR_W-1:0] A = 32'h1240, B = 32'h3440, C = 32'h5640, D = 32'h7840,
                                 E = 32'h9A40, F = 32'hBC40, G = 32'hDE40;

   initial begin
      int ra, rb, rc, rd, rx, t0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state (one cycle after release)
      chk("R1", "alloc_ways", alloc_ways, WAYS);
      chk("R1", "in_use", in_use, 0);
      chk("R1", "tag_accesses", tag_accesses, 0);
      chk("R1", "lkp_done", lkp_done, 0);
      chk("R1", "cfg_err", cfg_err, 0);
      chk("R1", "occupancy", occupancy, 0);
      // R12 free-running counter
      t0 = int'(cycle_now);
      chk("R12", "cycle_now after reset", t0, 1);
      @(negedge clk);
      chk("R12", "cycle_now step", int'(cycle_now) - t0, 1);

      lookup(A, 0, 0, 0, 0, 0);                      // R3 cold miss
      fill(A, 1, 0, 0, 0, '0, ra);                   // R6 way0
      chk("R8", "in_use after first fill", in_use, 1);
      lookup(A, 0, 1, 0, ra, 1);                     // R2 hit
      lookup(A, 1, 0, 0, 0, 0);                      // R2 secure mismatch misses
      fill(B, 2, 20, 1, 0, '0, rb);
      lookup(B, 0, 1, 1, rb, 1);                     // R4 stretched latency
      fill(C, 1, 3, 2, 0, '0, rc);
      lookup(C, 0, 1, 2, rc, 1);                     // R4 remaining not above access latency
      fill(D, 3, 0, 3, 0, '0, rd);
      lookup(D, 0, 1, 3, rd, 1);
      lookup(D, 0, 1, 3, rd, 2);                     // R5 count grows
      chk("R8", "in_use full set", in_use, 4);
      chk("R8", "occ owner1", occ(1), 2);
      chk("R8", "occ owner3", occ(3), 1);

      fill(E, 0, 0, 3, 1, D, rx);                    // R6 all valid -> way N-1; R7 evicts D
      chk("R7", "replacements", replacements, 1);
      chk("R7", "ref_total", ref_total, 2);
      chk("R7", "occ old owner3", occ(3), 0);
      chk("R8", "occ new owner0", occ(0), 1);
      chk("R7", "in_use unchanged on replace", in_use, 4);

      cfg(0);
      chk("R9", "cfg_err on zero", cfg_err, 1);
      chk("R9", "limit kept after zero", alloc_ways, 4);
      cfg(5);
      chk("R9", "cfg_err above WAYS", cfg_err, 1);
      cfg(2); lim = 2;
      chk("R9", "limit set", alloc_ways, 2);
      chk("R9", "no error on good write", cfg_err, 0);
      lookup(C, 0, 0, 0, 0, 0);                      // R9 way2 beyond limit misses
      fill(F, 2, 0, 1, 1, B, rx);                    // R6 victim N-1 under limit
      chk("R7", "replacements second", replacements, 2);
      chk("R7", "ref_total second", ref_total, 3);
      chk("R8", "occ owner2 swap", occ(2), 1);

      inval(1, 0);                                   // R10 drop A
      chk("R10", "in_use after invalidate", in_use, 3);
      chk("R10", "occ owner1 after invalidate", occ(1), 1);
      lookup(A, 0, 0, 0, 0, 0);
      inval(0, 0);                                   // R10 invalid target ignored
      chk("R10", "in_use after empty invalidate", in_use, 3);
      chk("R10", "occupancy after empty invalidate", occupancy,
          {CNT_W'(0), CNT_W'(1), CNT_W'(1), CNT_W'(1)});
      fill(G, 3, 0, 0, 0, '0, rx);                   // R6 lowest invalid way
      chk("R8", "in_use refilled", in_use, 4);
      chk("R8", "occ owner3 refill", occ(3), 1);

      @(negedge clk);
      chk("R11", "tag_accesses", tag_accesses, exp_tag);
      chk("R11", "data_accesses", data_accesses, exp_data);
      chk("R2", "scoreboard drained", sb_q.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule